// File: doc/BRIEF.md
# Power-Up Reset Delay Sequencer

This block keeps the rest of the device in reset after power-on until the supply and the chosen primary clock can be trusted. Three delays start together when the power-on reset input goes inactive. The first is a power-up timer of fixed length. The second is an oscillator start-up count of 1024 cycles, clocked by the raw crystal oscillator. The third is a controller-ready delay. The power-up timer and the controller-ready delay are counted on a free-running reference clock. The single output goes high once every delay that applies to the selected mode has finished.

The primary clock mode is captured while the power-on reset is held. In crystal mode all three delays apply, and the controller-ready delay runs alongside the others rather than after them. In external-clock, internal-oscillator and the reserved mode only the controller-ready delay applies. The result of the oscillator count crosses into the reference domain through a two-flop synchronizer.

Top module: `pur_reset_sequencer`

## Requirements
- R1: While `por_n` is low, `rst_release` is low. A low `por_n` sampled on a `ref_clk` edge drives `rst_release` low after that edge, including the edge on which it would otherwise have risen.
- R2: With the captured mode not equal to crystal (`prim_mode` 1 = external clock, 2 = internal oscillator, 3 = reserved), `rst_release` is low after `ref_clk` edge READY_CYCLES and high after edge READY_CYCLES+1. Edges are counted from the first edge on which `por_n` is high.
- R3: With the captured mode equal to crystal (`prim_mode` 0), `rst_release` stays low through edge PWRT_CYCLES. When the oscillator count finishes earlier, it rises exactly after edge PWRT_CYCLES+1, so the controller-ready delay adds nothing.
- R4: In crystal mode `rst_release` stays low until 1024 `osc_clk` cycles have been counted since reset. If `osc_clk` stops before that count is reached, `rst_release` stays low.
- R5: In crystal mode with a slow oscillator, `rst_release` is still low before 1024 oscillator periods have elapsed. It rises within a few reference cycles after the count finishes, the delay being set by the synchronizer and the output register.
- R6: `prim_mode` is sampled only while `por_n` is low. Changes to it after reset is released have no effect on `rst_release`.
- R7: A new low pulse on `por_n` at any time clears all delays, and the full sequence restarts from the new release of `por_n`.
- R8: Once high, `rst_release` stays high until `por_n` goes low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running internal reference clock |
| por_n | input | 1 | Power-on reset, active low, synchronous to ref_clk, at least four oscillator periods long |
| prim_mode | input | 2 | Primary clock mode: 0 crystal, 1 external clock, 2 internal oscillator, 3 reserved |
| osc_clk | input | 1 | Raw crystal oscillator clock |
| rst_release | output | 1 | High when the device may leave reset |

## Verification
The delay expiry and a fresh power-on reset can fall on the same reference edge. The bench provokes this by pulling `por_n` low in the cycle just before the controller-ready delay would release the output, and it expects the output to stay low. The expiry of the oscillator count and of the power-up timer can also overlap in crystal mode. A fast oscillator lets the power-up timer decide the release edge exactly, and a slow oscillator lets the count decide it; the second case is judged against a window, not a single edge. Random trials mix modes, reset pulse widths and sampling points, and compare each sample with an expected value computed from the requirements.

// File: rtl/pur_pkg.sv
// Shared types and constants for the power-up reset sequencer.
// Assumes a two-bit primary mode field; value 3 is reserved and
// behaves like a non-crystal source.
package pur_pkg;

    typedef enum logic [1:0] {
        PM_XTAL   = 2'd0,
        PM_EXTCLK = 2'd1,
        PM_INTOSC = 2'd2,
        PM_RSVD   = 2'd3
    } prim_mode_e;

    // Fixed oscillator start-up count
    localparam int OSC_STARTUP_CYCLES = 1024;

    // True when the mode needs the oscillator start-up count
    function automatic logic needs_osc_count(input logic [1:0] m);
        return m == PM_XTAL;
    endfunction

endpackage

// File: rtl/pur_delay_counter.sv
// Saturating delay counter. Counts clock edges while rst_n is high
// and raises done once LEN edges have been seen. Synchronous
// active-low reset. Assumes LEN >= 1.
module pur_delay_counter #(
    parameter int LEN = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int W = $clog2(LEN + 1);
    localparam logic [W-1:0] LAST = W'(LEN);

    logic [W-1:0] cnt;

    // Count up to LAST and hold there
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LAST);

endmodule

// File: rtl/pur_sync.sv
// Multi-stage synchronizer for a single level signal into clk.
// Synchronous active-low reset clears every stage. Assumes the
// input is a level that stays put for many destination cycles.
module pur_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg;

    // First stage samples the asynchronous input
    always_ff @(posedge clk) begin
        if (!rst_n)
            stg[0] <= 1'b0;
        else
            stg[0] <= d;
    end

    genvar i;
    generate
        for (i = 1; i < STAGES; i++) begin : g_stage
            // Each further stage resolves metastability of the one before
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stg[i] <= 1'b0;
                else
                    stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/pur_osc_startup.sv
// Oscillator start-up counter in the raw oscillator domain. The
// power-on reset is brought into osc_clk through two flops and
// then clears a counter of the fixed start-up length. Assumes the
// reset pulse lasts at least four oscillator periods and that the
// oscillator runs while reset is applied.
module pur_osc_startup (
    input  logic osc_clk,
    input  logic por_n,
    output logic done
);
    import pur_pkg::*;

    logic [1:0] rst_sync;
    logic       osc_rst_n;

    // Bring the power-on reset into the oscillator domain
    always_ff @(posedge osc_clk) begin
        rst_sync <= {rst_sync[0], por_n};
    end

    assign osc_rst_n = rst_sync[1];

    pur_delay_counter #(
        .LEN (OSC_STARTUP_CYCLES)
    ) u_ost_cnt (
        .clk   (osc_clk),
        .rst_n (osc_rst_n),
        .done  (done)
    );

endmodule

// File: rtl/pur_reset_sequencer.sv
// Top of the power-up reset delay sequencer. The primary mode is
// captured during reset. Two delays run on ref_clk: the power-up
// timer and the controller-ready delay. The oscillator start-up
// count runs on osc_clk. All start together; rst_release rises on
// the first ref_clk edge after every applicable delay is done.
// Assumes por_n is synchronous to ref_clk.
module pur_reset_sequencer #(
    parameter int PWRT_CYCLES  = 64,
    parameter int READY_CYCLES = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       ref_clk,
    input  logic       por_n,
    input  logic [1:0] prim_mode,
    input  logic       osc_clk,
    output logic       rst_release
);
    import pur_pkg::*;

    logic [1:0] mode_q;
    logic       xtal_sel;
    logic       pwrt_done;
    logic       ready_done;
    logic       osc_done;
    logic       osc_done_ref;
    logic       all_done;

    // Capture the primary mode only while reset is held
    always_ff @(posedge ref_clk) begin
        if (!por_n)
            mode_q <= prim_mode;
    end

    assign xtal_sel = needs_osc_count(mode_q);

    pur_delay_counter #(
        .LEN (PWRT_CYCLES)
    ) u_pwrt (
        .clk   (ref_clk),
        .rst_n (por_n),
        .done  (pwrt_done)
    );

    pur_delay_counter #(
        .LEN (READY_CYCLES)
    ) u_ready (
        .clk   (ref_clk),
        .rst_n (por_n),
        .done  (ready_done)
    );

    pur_osc_startup u_ost (
        .osc_clk (osc_clk),
        .por_n   (por_n),
        .done    (osc_done)
    );

    pur_sync #(
        .STAGES (SYNC_STAGES)
    ) u_ost_sync (
        .clk   (ref_clk),
        .rst_n (por_n),
        .d     (osc_done),
        .q     (osc_done_ref)
    );

    // Combine the delays that apply to the captured mode
    always_comb begin
        if (xtal_sel)
            all_done = ready_done & pwrt_done & osc_done_ref;
        else
            all_done = ready_done;
    end

    // Register the release so that it rises one edge after completion
    always_ff @(posedge ref_clk) begin
        if (!por_n)
            rst_release <= 1'b0;
        else
            rst_release <= all_done;
    end

endmodule

// File: rtl/pur_reset_sequencer_chk.sv
// Assertion checker for pur_reset_sequencer, attached by bind.
// Keeps its own count of edges since reset release and its own
// copy of the mode captured during reset.
module pur_reset_sequencer_chk #(
    parameter int PWRT_CYCLES  = 64,
    parameter int READY_CYCLES = 8
) (
    input logic       ref_clk,
    input logic       por_n,
    input logic [1:0] prim_mode,
    input logic       rst_release,
    input logic       osc_done_ref
);
    localparam int MAXV = PWRT_CYCLES + READY_CYCLES + 4;
    localparam int W    = $clog2(MAXV + 1);
    localparam logic [W-1:0] SAT     = W'(MAXV);
    localparam logic [W-1:0] PWRT_W  = W'(PWRT_CYCLES);
    localparam logic [W-1:0] READY_W = W'(READY_CYCLES);

    logic [W-1:0] since;
    logic         xtal_q;
    logic         por_n_q;
    logic         valid_q = 1'b0;

    // Edges seen with reset released, saturating
    always_ff @(posedge ref_clk) begin
        if (!por_n)
            since <= '0;
        else if (since != SAT)
            since <= since + 1'b1;
    end

    // Own copy of the crystal selection taken during reset
    always_ff @(posedge ref_clk) begin
        if (!por_n)
            xtal_q <= (prim_mode == 2'd0);
    end

    // Previous reset level, for the reset-hold check
    always_ff @(posedge ref_clk) begin
        por_n_q <= por_n;
        valid_q <= 1'b1;
        if (valid_q && !por_n_q)
            assert_hold_in_reset_R1: assert (!rst_release);
    end

    assert_no_early_ready_R2: assert property (@(posedge ref_clk) disable iff (!por_n)
        rst_release |-> (since > READY_W));

    assert_ready_release_R2: assert property (@(posedge ref_clk) disable iff (!por_n)
        (!xtal_q && since == READY_W) |=> rst_release);

    assert_no_early_pwrt_R3: assert property (@(posedge ref_clk) disable iff (!por_n)
        (xtal_q && rst_release) |-> (since > PWRT_W));

    assert_osc_needed_R4: assert property (@(posedge ref_clk) disable iff (!por_n)
        (xtal_q && rst_release) |-> osc_done_ref);

    assert_release_sticky_R8: assert property (@(posedge ref_clk) disable iff (!por_n)
        rst_release |=> rst_release);

endmodule

bind pur_reset_sequencer pur_reset_sequencer_chk #(
    .PWRT_CYCLES  (PWRT_CYCLES),
    .READY_CYCLES (READY_CYCLES)
) u_chk (
    .ref_clk      (ref_clk),
    .por_n        (por_n),
    .prim_mode    (prim_mode),
    .rst_release  (rst_release),
    .osc_done_ref (osc_done_ref)
);

// File: tb/pur_reset_sequencer_tb.sv
`timescale 1ns/1ps
// Bench for the power-up reset delay sequencer: directed corners
// plus seeded random trials, checked against bench-side expectations.
module pur_reset_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PWRT  = 200;
    localparam int READY = 8;

    logic       ref_clk = 1'b0;
    logic       osc_clk = 1'b0;
    logic       por_n = 1'b0;
    logic [1:0] prim_mode = 2'd2;
    logic       rst_release;
    logic       osc_en = 1'b1;
    real        osc_half = 0.5;

    int checks = 0;
    int fails  = 0;

    pur_reset_sequencer #(
        .PWRT_CYCLES  (PWRT),
        .READY_CYCLES (READY)
    ) u_dut (
        .ref_clk     (ref_clk),
        .por_n       (por_n),
        .prim_mode   (prim_mode),
        .osc_clk     (osc_clk),
        .rst_release (rst_release)
    );

    always #(CLK_PERIOD / 2) ref_clk = ~ref_clk;

    always begin
        if (osc_en) begin
            #(osc_half) osc_clk = ~osc_clk;
        end else begin
            #1;
        end
    end

    function automatic bit exp_release(input logic [1:0] m, input int k);
        if (m == 2'd0)
            return k > PWRT;
        return k > READY;
    endfunction

    task automatic check(input bit got, input bit exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic run_edges(input int n);
        repeat (n) @(posedge ref_clk);
        @(negedge ref_clk);
    endtask

    // Hold reset for len cycles with mode m, then release at a negedge
    task automatic por_pulse(input int len, input logic [1:0] m);
        @(negedge ref_clk);
        por_n = 1'b0;
        prim_mode = m;
        repeat (len) @(negedge ref_clk);
        por_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (3) @(negedge ref_clk);
        check(rst_release, 1'b0, "R1", "held during reset");

        // R2: internal oscillator mode, exact edge
        por_pulse(3, 2'd2);
        run_edges(READY);
        check(rst_release, 1'b0, "R2", "low after ready edge");
        run_edges(1);
        check(rst_release, 1'b1, "R2", "high one edge later");

        // R8: stays high
        begin
            bit dropped = 1'b0;
            for (int i = 0; i < 300; i++) begin
                run_edges(1);
                if (!rst_release) dropped = 1'b1;
            end
            check(dropped, 1'b0, "R8", "release stays high");
        end

        // R1: reset after release drops the output on the next edge
        por_n = 1'b0;
        run_edges(1);
        check(rst_release, 1'b0, "R1", "drop after reset edge");

        // R2: external clock and reserved modes
        por_pulse(2, 2'd1);
        run_edges(READY);
        check(rst_release, 1'b0, "R2", "extclk before");
        run_edges(1);
        check(rst_release, 1'b1, "R2", "extclk after");
        por_pulse(2, 2'd3);
        run_edges(READY + 1);
        check(rst_release, 1'b1, "R2", "reserved mode");

        // R1/R7: reset arrives in the cycle the release would rise
        por_pulse(2, 2'd2);
        run_edges(READY);
        por_n = 1'b0;
        run_edges(1);
        check(rst_release, 1'b0, "R1", "reset wins over expiry");
        por_n = 1'b1;
        run_edges(READY);
        check(rst_release, 1'b0, "R7", "restart before");
        run_edges(1);
        check(rst_release, 1'b1, "R7", "restart after");

        // R3: crystal with fast oscillator, timer decides
        por_pulse(3, 2'd0);
        run_edges(PWRT);
        check(rst_release, 1'b0, "R3", "low at timer end");
        run_edges(1);
        check(rst_release, 1'b1, "R3", "high one edge later");

        // R7: crystal restart mid-sequence
        por_pulse(3, 2'd0);
        run_edges(150);
        por_n = 1'b0;
        run_edges(2);
        por_n = 1'b1;
        run_edges(PWRT);
        check(rst_release, 1'b0, "R7", "crystal restart before");
        run_edges(1);
        check(rst_release, 1'b1, "R7", "crystal restart after");

        // R6: mode change after release is ignored (internal latched)
        por_pulse(2, 2'd2);
        run_edges(3);
        prim_mode = 2'd0;
        run_edges(READY - 2);
        check(rst_release, 1'b1, "R6", "latched internal ignores crystal");

        // R6: crystal latched, input moved to internal
        por_pulse(3, 2'd0);
        run_edges(3);
        prim_mode = 2'd2;
        run_edges(READY - 2);
        check(rst_release, 1'b0, "R6", "latched crystal ignores internal");
        run_edges(PWRT - READY);
        check(rst_release, 1'b1, "R6", "latched crystal releases at timer");

        // R5: slow oscillator, count decides
        osc_half = 2.0;
        por_pulse(5, 2'd0);
        run_edges(409);
        check(rst_release, 1'b0, "R5", "low before count done");
        run_edges(11);
        check(rst_release, 1'b1, "R5", "high within window");
        osc_half = 0.5;

        // R4: oscillator stops before the count completes
        por_pulse(3, 2'd0);
        run_edges(20);
        osc_en = 1'b0;
        run_edges(400);
        check(rst_release, 1'b0, "R4", "held with stopped oscillator");
        osc_en = 1'b1;
        por_pulse(3, 2'd2);
        run_edges(READY + 1);
        check(rst_release, 1'b1, "R4", "recovers in internal mode");

        // Random trials over modes, pulse widths and sample points
        for (int t = 0; t < 24; t++) begin
            logic [1:0] m;
            int len;
            int k;
            m   = 2'($urandom % 4);
            len = 1 + int'($urandom % 3);
            k   = 1 + int'($urandom % ((m == 2'd0) ? 230 : 14));
            por_pulse(len, m);
            run_edges(k);
            if (m == 2'd0)
                check(rst_release, exp_release(m, k), "R3", "random crystal");
            else
                check(rst_release, exp_release(m, k), "R2", "random non-crystal");
        end

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule